// File: doc/BRIEF.md
# Programmable Almost-Flag Offset Unit

This block sits beside a FIFO's pointer logic and turns the FIFO's word count into two warning flags. The almost-empty flag rises when the number of stored words is at or below an empty-side offset. The almost-full flag rises when the number of free locations is at or below a full-side offset. Each offset has its own register, so the two thresholds are set independently.

The offsets come from three sources. The first is a table of eight preset values chosen while master reset is held. The second is a bit-serial shift on the write clock. The third is a whole-word parallel write on the write clock. A load sequencer in the write domain has two states, `PTR_EMPTY` and `PTR_FULL`, and it steers every load into the empty-side register first and the full-side register second. After the full-side register it wraps back to the empty side. A readback sequencer in the read domain uses the same two states and returns the offsets in the same alternating order on a parallel bus.

The flags are either registered in their own clock domain (synchronous timing) or driven straight from the comparators (asynchronous timing). The timing mode is captured at master reset. Partial reset only returns both sequencers to `PTR_EMPTY`; it leaves the offsets and the timing mode untouched.

State transitions of both sequencers:
- `PTR_EMPTY -> PTR_FULL` on a parallel load, on the last bit of a serial load, or on a readback.
- `PTR_FULL -> PTR_EMPTY` on the same events.
- Any state -> `PTR_EMPTY` on master or partial reset.

Top module: `pflag_offset_unit`

## Requirements
- R1: While `mrst_n` is low, both offsets are preset to 2^(k+3)-1, where k = {ld, dflt_sel[1], dflt_sel[0]} (ld is the most significant bit). This gives 7, 15, 31, 63, 127, 255, 511 or 1023.
- R2: A write-clock edge with `ld` and `wr_en` both high stores `din` into the register under the load pointer. The pointer starts at the empty-side register, moves to the full-side register, then wraps back.
- R3: A write-clock edge with `ld` and `ser_en` high and `wr_en` low shifts `ser_din` into the register under the load pointer, least significant bit first. After ADDR_W such edges the pointer advances. If `wr_en` is also high, the parallel load takes precedence.
- R4: With `ld` low, `wr_en` and `ser_en` leave both offsets unchanged.
- R5: A read-clock edge with `ld` and `rd_en` high places the next offset on `rb_data` (empty-side first, then full-side, alternating). The value is visible after that edge. Otherwise `rb_data` holds its value.
- R6: `almost_empty` is high exactly when `rd_count` <= the empty-side offset.
- R7: `almost_full` is high exactly when 2^ADDR_W - `wr_count` <= the full-side offset.
- R8: `flag_sync` is sampled during master reset. When it is 1, each flag reflects the count and offset one edge of its own clock later. When it is 0, each flag follows its count with no clock edge.
- R9: Partial reset returns both sequencers to the empty-side register. It keeps both offsets and the timing mode.
- R10: In synchronous timing, while master reset is held, `almost_empty` is 1 and `almost_full` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| rd_clk | input | 1 | Read-domain clock |
| mrst_n | input | 1 | Master reset, active low, synchronous in each domain |
| prst_n | input | 1 | Partial reset, active low |
| dflt_sel | input | 2 | Low two bits of the preset index |
| flag_sync | input | 1 | Timing mode sampled at master reset (1 = registered flags) |
| ld | input | 1 | Offset access qualifier |
| wr_en | input | 1 | Parallel load enable |
| ser_en | input | 1 | Serial load enable |
| ser_din | input | 1 | Serial load data bit |
| din | input | ADDR_W | Parallel load data |
| rd_en | input | 1 | Readback enable |
| wr_count | input | ADDR_W+1 | Word count seen by the write domain |
| rd_count | input | ADDR_W+1 | Word count seen by the read domain |
| almost_empty | output | 1 | Programmable almost-empty flag |
| almost_full | output | 1 | Programmable almost-full flag |
| rb_data | output | ADDR_W | Offset readback bus |

## Verification
A parallel load or a readback takes effect on the one clock edge that sees its controls. The bench therefore drives controls on a falling edge and samples the result on the next falling edge. A serial load needs ADDR_W consecutive qualified edges before the pointer moves, and the bench sends exactly that many bits before it reads back. In asynchronous timing the flags are checked one nanosecond after the count changes, with no clock edge in between. In synchronous timing the flags are checked twice: just after the count changes, where the old value must persist, and at the following falling edge, where the new value is due.

// File: rtl/pflag_pkg.sv
package pflag_pkg;

    typedef enum logic {
        PTR_EMPTY = 1'b0,
        PTR_FULL  = 1'b1
    } ofs_ptr_e;

    localparam int unsigned PRESET_BASE_SHIFT = 3;

endpackage

// File: rtl/pflag_load_seq.sv
module pflag_load_seq
    import pflag_pkg::*;
#(
    parameter int unsigned ADDR_W = 10
) (
    input  logic              clk,
    input  logic              mrst_n,
    input  logic              prst_n,
    input  logic [1:0]        dflt_sel,
    input  logic              flag_sync,
    input  logic              ld,
    input  logic              wr_en,
    input  logic              ser_en,
    input  logic              ser_din,
    input  logic [ADDR_W-1:0] din,
    output logic [ADDR_W-1:0] ofs_ae,
    output logic [ADDR_W-1:0] ofs_af,
    output logic              tmode
);
    localparam int unsigned BC_W = $clog2(ADDR_W);
    localparam logic [BC_W-1:0] BC_LAST = BC_W'(ADDR_W - 1);
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    ofs_ptr_e          ptr_q, ptr_d;
    logic [BC_W-1:0]   bcnt_q, bcnt_d;
    logic              upd_ae, upd_af;
    logic [ADDR_W-1:0] new_val;
    logic [ADDR_W-1:0] cur_val;
    logic [ADDR_W-1:0] preset;
    logic [3:0]        preset_idx;
    logic              par_go, ser_go;

    assign preset_idx = {1'b0, ld, dflt_sel} + 4'(PRESET_BASE_SHIFT);
    assign preset     = (ONE << preset_idx) - ONE;
    assign par_go     = ld & wr_en;
    assign ser_go     = ld & ser_en & ~wr_en;

    // State register
    always_ff @(posedge clk) begin
        if (!mrst_n || !prst_n) begin
            ptr_q  <= PTR_EMPTY;
            bcnt_q <= '0;
        end else begin
            ptr_q  <= ptr_d;
            bcnt_q <= bcnt_d;
        end
    end

    // Next state and load outputs
    always_comb begin
        ptr_d   = ptr_q;
        bcnt_d  = bcnt_q;
        upd_ae  = 1'b0;
        upd_af  = 1'b0;
        cur_val = (ptr_q == PTR_EMPTY) ? ofs_ae : ofs_af;
        new_val = cur_val;
        if (par_go) begin
            new_val = din;
            bcnt_d  = '0;
        end else if (ser_go) begin
            new_val = {ser_din, cur_val[ADDR_W-1:1]};
            bcnt_d  = (bcnt_q == BC_LAST) ? '0 : bcnt_q + 1'b1;
        end
        unique case (ptr_q)
            PTR_EMPTY: begin
                upd_ae = par_go | ser_go;
                if (par_go || (ser_go && bcnt_q == BC_LAST)) ptr_d = PTR_FULL;
            end
            PTR_FULL: begin
                upd_af = par_go | ser_go;
                if (par_go || (ser_go && bcnt_q == BC_LAST)) ptr_d = PTR_EMPTY;
            end
        endcase
    end

    // Offset registers and timing mode
    always_ff @(posedge clk) begin
        if (!mrst_n) begin
            ofs_ae <= preset;
            ofs_af <= preset;
            tmode  <= flag_sync;
        end else begin
            if (upd_ae) ofs_ae <= new_val;
            if (upd_af) ofs_af <= new_val;
        end
    end
endmodule

// File: rtl/pflag_readback.sv
module pflag_readback
    import pflag_pkg::*;
#(
    parameter int unsigned ADDR_W = 10
) (
    input  logic              clk,
    input  logic              mrst_n,
    input  logic              prst_n,
    input  logic              ld,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] ofs_ae,
    input  logic [ADDR_W-1:0] ofs_af,
    output logic [ADDR_W-1:0] rb_data
);
    ofs_ptr_e          rptr_q, rptr_d;
    logic              rb_go;
    logic [ADDR_W-1:0] rb_d;

    assign rb_go = ld & rd_en;

    // State register
    always_ff @(posedge clk) begin
        if (!mrst_n || !prst_n) rptr_q <= PTR_EMPTY;
        else                    rptr_q <= rptr_d;
    end

    // Next state and readback selection
    always_comb begin
        rptr_d = rptr_q;
        rb_d   = rb_data;
        unique case (rptr_q)
            PTR_EMPTY: if (rb_go) begin
                rb_d   = ofs_ae;
                rptr_d = PTR_FULL;
            end
            PTR_FULL: if (rb_go) begin
                rb_d   = ofs_af;
                rptr_d = PTR_EMPTY;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!mrst_n) rb_data <= '0;
        else         rb_data <= rb_d;
    end
endmodule

// File: rtl/pflag_flag_gen.sv
module pflag_flag_gen #(
    parameter int unsigned ADDR_W  = 10,
    parameter bit          IS_FULL = 1'b0
) (
    input  logic              clk,
    input  logic              mrst_n,
    input  logic              sync_mode,
    input  logic [ADDR_W:0]   count,
    input  logic [ADDR_W-1:0] ofs,
    output logic              flag
);
    localparam logic [ADDR_W:0] DEPTH_C   = (ADDR_W+1)'(1) << ADDR_W;
    localparam logic            RESET_VAL = !IS_FULL;

    logic [ADDR_W:0] level;
    logic            hit;
    logic            flag_q;

    generate
        if (IS_FULL) begin : g_full
            assign level = DEPTH_C - count;
        end else begin : g_empty
            assign level = count;
        end
    endgenerate

    assign hit = (level <= {1'b0, ofs});

    always_ff @(posedge clk) begin
        if (!mrst_n) flag_q <= RESET_VAL;
        else         flag_q <= hit;
    end

    assign flag = sync_mode ? flag_q : hit;
endmodule

// File: rtl/pflag_offset_unit.sv
module pflag_offset_unit #(
    parameter int unsigned ADDR_W = 10
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              mrst_n,
    input  logic              prst_n,
    input  logic [1:0]        dflt_sel,
    input  logic              flag_sync,
    input  logic              ld,
    input  logic              wr_en,
    input  logic              ser_en,
    input  logic              ser_din,
    input  logic [ADDR_W-1:0] din,
    input  logic              rd_en,
    input  logic [ADDR_W:0]   wr_count,
    input  logic [ADDR_W:0]   rd_count,
    output logic              almost_empty,
    output logic              almost_full,
    output logic [ADDR_W-1:0] rb_data
);
    logic [ADDR_W-1:0] ofs_ae;
    logic [ADDR_W-1:0] ofs_af;
    logic              tmode;

    pflag_load_seq #(.ADDR_W(ADDR_W)) u_load (
        .clk(wr_clk), .mrst_n(mrst_n), .prst_n(prst_n), .dflt_sel(dflt_sel),
        .flag_sync(flag_sync), .ld(ld), .wr_en(wr_en), .ser_en(ser_en),
        .ser_din(ser_din), .din(din), .ofs_ae(ofs_ae), .ofs_af(ofs_af),
        .tmode(tmode)
    );

    pflag_readback #(.ADDR_W(ADDR_W)) u_rb (
        .clk(rd_clk), .mrst_n(mrst_n), .prst_n(prst_n), .ld(ld),
        .rd_en(rd_en), .ofs_ae(ofs_ae), .ofs_af(ofs_af), .rb_data(rb_data)
    );

    pflag_flag_gen #(.ADDR_W(ADDR_W), .IS_FULL(1'b0)) u_ae (
        .clk(rd_clk), .mrst_n(mrst_n), .sync_mode(tmode),
        .count(rd_count), .ofs(ofs_ae), .flag(almost_empty)
    );

    pflag_flag_gen #(.ADDR_W(ADDR_W), .IS_FULL(1'b1)) u_af (
        .clk(wr_clk), .mrst_n(mrst_n), .sync_mode(tmode),
        .count(wr_count), .ofs(ofs_af), .flag(almost_full)
    );
endmodule

// File: rtl/pflag_offset_unit_chk.sv
module pflag_offset_unit_chk #(
    parameter int unsigned ADDR_W = 10
) (
    input logic              wr_clk,
    input logic              rd_clk,
    input logic              mrst_n,
    input logic              prst_n,
    input logic              ld,
    input logic              rd_en,
    input logic [ADDR_W:0]   wr_count,
    input logic [ADDR_W:0]   rd_count,
    input logic              almost_empty,
    input logic              almost_full,
    input logic [ADDR_W-1:0] rb_data,
    input logic [ADDR_W-1:0] ofs_ae,
    input logic [ADDR_W-1:0] ofs_af,
    input logic              tmode
);
    localparam logic [ADDR_W:0] DEPTH_C = (ADDR_W+1)'(1) << ADDR_W;

    AST_OFS_HOLD_NO_LD: assert property (@(posedge wr_clk) disable iff (!mrst_n)
        !ld |=> ($stable(ofs_ae) && $stable(ofs_af))); // R4

    AST_PRST_KEEPS_OFS: assert property (@(posedge wr_clk) disable iff (!mrst_n)
        !prst_n |=> ($stable(ofs_ae) && $stable(ofs_af))); // R9

    AST_TMODE_HELD: assert property (@(posedge wr_clk) disable iff (!mrst_n)
        mrst_n |=> $stable(tmode)); // R8

    AST_RB_HOLD: assert property (@(posedge rd_clk) disable iff (!mrst_n)
        !(ld && rd_en) |=> $stable(rb_data)); // R5

    AST_EMPTY_FLAGS_AE: assert property (@(posedge rd_clk) disable iff (!mrst_n)
        (!tmode && rd_count == '0) |-> almost_empty); // R6

    AST_FULL_FLAGS_AF: assert property (@(posedge wr_clk) disable iff (!mrst_n)
        (!tmode && wr_count == DEPTH_C) |-> almost_full); // R7

    AST_AE_SYNC_LAG: assert property (@(posedge rd_clk) disable iff (!mrst_n)
        (tmode && $past(mrst_n)) |-> (almost_empty == ($past(rd_count) <= {1'b0, $past(ofs_ae)}))); // R8
endmodule

bind pflag_offset_unit pflag_offset_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .mrst_n(mrst_n), .prst_n(prst_n),
    .ld(ld), .rd_en(rd_en), .wr_count(wr_count), .rd_count(rd_count),
    .almost_empty(almost_empty), .almost_full(almost_full), .rb_data(rb_data),
    .ofs_ae(ofs_ae), .ofs_af(ofs_af), .tmode(tmode)
);

// File: tb/pflag_offset_unit_bench.sv
module pflag_offset_unit_bench;
    localparam int AW = 10;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic mrst_n = 1'b0, prst_n = 1'b1;
    logic [1:0] dflt_sel = '0;
    logic flag_sync = 1'b0, ld = 1'b0, wr_en = 1'b0, ser_en = 1'b0, ser_din = 1'b0, rd_en = 1'b0;
    logic [AW-1:0] din = '0;
    logic [AW:0] wr_count = '0, rd_count = '0;
    logic almost_empty, almost_full;
    logic [AW-1:0] rb_data;
    int n_run = 0, n_fail = 0;
    int got_ae, got_af;

    always #2 clk = ~clk;

    pflag_offset_unit #(.ADDR_W(AW)) u_pflag_offset_unit (
        .wr_clk(clk), .rd_clk(clk), .mrst_n(mrst_n), .prst_n(prst_n),
        .dflt_sel(dflt_sel), .flag_sync(flag_sync), .ld(ld), .wr_en(wr_en),
        .ser_en(ser_en), .ser_din(ser_din), .din(din), .rd_en(rd_en),
        .wr_count(wr_count), .rd_count(rd_count), .almost_empty(almost_empty),
        .almost_full(almost_full), .rb_data(rb_data)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic mreset(input int k, input logic sync);
        @(negedge clk);
        mrst_n = 1'b0; prst_n = 1'b1;
        ld = k[2]; dflt_sel = k[1:0]; flag_sync = sync;
        repeat (2) @(negedge clk);
        if (sync) begin
            chk("R10 ae in reset", int'(almost_empty), 1);
            chk("R10 af in reset", int'(almost_full), 0);
        end
        mrst_n = 1'b1; ld = 1'b0;
    endtask

    task automatic preset_part;
        @(negedge clk); prst_n = 1'b0;
        @(negedge clk); prst_n = 1'b1;
    endtask

    task automatic rb_read(output int v);
        @(negedge clk); ld = 1'b1; rd_en = 1'b1;
        @(negedge clk); v = int'(rb_data); ld = 1'b0; rd_en = 1'b0;
    endtask

    task automatic par_load(input int v);
        @(negedge clk); ld = 1'b1; wr_en = 1'b1; din = AW'(v);
        @(negedge clk); ld = 1'b0; wr_en = 1'b0;
    endtask

    task automatic ser_load(input int v);
        for (int i = 0; i < AW; i++) begin
            @(negedge clk); ld = 1'b1; ser_en = 1'b1; ser_din = v[i];
        end
        @(negedge clk); ld = 1'b0; ser_en = 1'b0;
    endtask

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int prev;
        // R1 presets, all eight indices
        for (int k = 0; k < 8; k++) begin
            mreset(k, k[0]);
            rb_read(got_ae); rb_read(got_af);
            chk("R1 preset empty-side", got_ae, (1 << (k + 3)) - 1);
            chk("R1 preset full-side", got_af, (1 << (k + 3)) - 1);
        end

        // R2 parallel order and wrap; R5 alternating readback
        mreset(0, 1'b0);
        par_load(5); par_load(9); par_load(100);
        rb_read(got_ae); rb_read(got_af);
        chk("R2 wrap to empty-side", got_ae, 100);
        chk("R2 full-side", got_af, 9);
        rb_read(got_ae);
        chk("R5 readback wraps", got_ae, 100);

        // R5 hold without ld
        @(negedge clk); rd_en = 1'b1;
        repeat (3) @(negedge clk);
        chk("R5 hold rd_en only", int'(rb_data), 100);
        rd_en = 1'b0;

        // R4 no load without ld
        preset_part;
        @(negedge clk); wr_en = 1'b1; ser_en = 1'b1; ser_din = 1'b1; din = AW'(777);
        repeat (3) @(negedge clk);
        wr_en = 1'b0; ser_en = 1'b0;
        rb_read(got_ae); rb_read(got_af);
        chk("R4 empty-side untouched", got_ae, 100);
        chk("R4 full-side untouched", got_af, 9);

        // R3 serial loading, then parallel precedence
        preset_part;
        ser_load(300); ser_load(77);
        rb_read(got_ae); rb_read(got_af);
        chk("R3 serial empty-side", got_ae, 300);
        chk("R3 serial full-side", got_af, 77);
        preset_part;
        @(negedge clk); ld = 1'b1; wr_en = 1'b1; ser_en = 1'b1; ser_din = 1'b1; din = AW'(12);
        @(negedge clk); ld = 1'b0; wr_en = 1'b0; ser_en = 1'b0;
        rb_read(got_ae); rb_read(got_af);
        chk("R3 parallel wins", got_ae, 12);
        chk("R3 full-side kept", got_af, 77);

        // R6/R7 asynchronous sweeps with offsets 5 and 9
        preset_part;
        par_load(5); par_load(9);
        for (int c = 0; c <= 20; c++) begin
            @(negedge clk); rd_count = (AW+1)'(c); #1;
            chk("R6 async ae", int'(almost_empty), (c <= 5) ? 1 : 0);
        end
        for (int c = DEPTH - 20; c <= DEPTH; c++) begin
            @(negedge clk); wr_count = (AW+1)'(c); #1;
            chk("R7 async af", int'(almost_full), ((DEPTH - c) <= 9) ? 1 : 0);
        end

        // R9 partial reset keeps offsets and timing mode
        preset_part;
        @(negedge clk); rd_count = (AW+1)'(5); #1;
        chk("R9 async mode kept", int'(almost_empty), 1);
        rd_count = (AW+1)'(6); #1;
        chk("R9 async mode kept", int'(almost_empty), 0);
        rb_read(got_ae); rb_read(got_af);
        chk("R9 empty-side kept", got_ae, 5);
        chk("R9 full-side kept", got_af, 9);

        // R8 synchronous timing, preset index 2 (31)
        mreset(2, 1'b1);
        rd_count = '0; wr_count = '0;
        @(negedge clk);
        prev = 1;
        for (int c = 0; c <= 40; c++) begin
            rd_count = (AW+1)'(c); #1;
            chk("R8 ae not yet updated", int'(almost_empty), prev);
            @(negedge clk);
            prev = (c <= 31) ? 1 : 0;
            chk("R8 R6 sync ae", int'(almost_empty), prev);
        end
        prev = 0;
        for (int c = DEPTH - 40; c <= DEPTH; c++) begin
            wr_count = (AW+1)'(c); #1;
            chk("R8 af not yet updated", int'(almost_full), prev);
            @(negedge clk);
            prev = ((DEPTH - c) <= 31) ? 1 : 0;
            chk("R8 R7 sync af", int'(almost_full), prev);
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule